// File: doc/BRIEF.md
# Sequencer Program Memory Byte Loader

This block gives a host an eight-bit register window onto a small program memory of 32-bit instruction words. The host selects one of four registers (control, data port, address low, address high) with a two-bit select code. It sets a word address through the two address registers and then streams bytes through the data port. Four byte writes, least significant first, build one instruction word. The word is committed to the memory together with the fourth byte, and the word address then moves on by one.

Reads through the data port return the bytes of the current word in the same order, and the address advances after the fourth byte is read. Data port access is gated by a load-enable bit in the control register. The control register also carries a self-clearing reset bit that zeroes the sequencer's program counter output, and a step bit that advances that counter by one. The other control bits are stored and driven out so that neighbouring logic can see them.

Top module: `prog_ram_loader`

## Requirements
- R1: After reset the control byte, both address registers, the program counter output and the internal byte index are 0. A read of the control register returns 0.
- R2: Four successive data-port writes with load enabled (control bit 0 = 1) form one word. The first byte lands in bits 7:0 and the fourth in bits 31:24. The word is written into memory when the fourth byte arrives.
- R3: The word address stays unchanged after data-port bytes one to three. It increments by one after the fourth byte and wraps from 511 to 0.
- R4: Select code 3 (address high) keeps only data bit 0 as address bit 8. Its other bits read back as 0. Select code 2 (address low) holds address bits 7:0.
- R5: With load disabled, data-port writes change neither memory, address nor byte index, and data-port reads return 0.
- R6: A write to either address register returns the byte index to 0. The next data-port access then uses byte 0 of the word.
- R7: Data-port reads (select code 1) with load enabled return bytes 7:0, 15:8, 23:16 and 31:24 of the current word in that order. The address advances after the fourth read.
- R8: Writing control bit 1 (sequencer reset) zeroes the program counter on the following clock. That bit then reads back as 0.
- R9: A control write (select code 0) with bit 2 (step) set and bits 1 and 0 clear increments the program counter by one.
- R10: Control bits 7 (parity-error disable), 6 (pause disable), 5 (fail disable), 4 (fast mode), 3 (breakpoint interrupt enable), 2 (step) and 0 (load) are stored as written. They appear on ctrl_o and on a control read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 2 | Register select: 0 control, 1 data port, 2 address low, 3 address high |
| host_wr | input | 1 | Write strobe for the selected register |
| host_rd | input | 1 | Read strobe; it advances the byte index on the data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register (combinational) |
| ctrl_o | output | 8 | Stored control byte |
| pc_o | output | ADDR_W | Sequencer program counter |

## Verification
The bench builds the block with its default values: a 9-bit word address and four bytes per word. This covers the full 512-word range, so the wrap from word 511 to word 0 is exercised through the one-bit high address register. The byte index crosses its last lane on both writes and reads. It is also cut short mid-word by address writes.

// File: rtl/prl_pkg.sv
package prl_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int IDX_W      = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_ADRLO = 2'd2,
    SEL_ADRHI = 2'd3
  } host_sel_e;

  localparam int CB_LOAD = 0;
  localparam int CB_SRST = 1;
  localparam int CB_STEP = 2;

  // byte lane i of a word, lane 0 least significant
  function automatic logic [BYTE_W-1:0] lane_of(input logic [WORD_W-1:0] w,
                                                input logic [IDX_W-1:0] i);
    return w[{i, 3'b000} +: BYTE_W];
  endfunction

  // a step command: step bit without reset and without load
  function automatic logic is_step_cmd(input logic [BYTE_W-1:0] d);
    return d[CB_STEP] && !d[CB_SRST] && !d[CB_LOAD];
  endfunction
endpackage

// File: rtl/prl_ctrl.sv
module prl_ctrl
  import prl_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [ADDR_W-1:0] pc_q
);
  logic step_ev;
  logic srst_ev;
  assign step_ev = we && is_step_cmd(wdata);
  assign srst_ev = ctrl_q[CB_SRST] && !we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pc_q   <= '0;
    end else begin
      if (ctrl_q[CB_SRST]) begin
        pc_q            <= '0;
        ctrl_q[CB_SRST] <= 1'b0;
      end
      if (we) begin
        ctrl_q <= wdata;
        if (step_ev) pc_q <= pc_q + 1'b1;
      end
    end
  end

  AST_SRST_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    srst_ev |=> !ctrl_q[CB_SRST]);                                  // R8
  AST_SRST_PC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    srst_ev |=> pc_q == '0);                                        // R8
  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> pc_q == $past(pc_q) + ADDR_W'(1));                  // R9
endmodule

// File: rtl/prl_addr_ptr.sv
module prl_addr_ptr
  import prl_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              step,
  input  logic [BYTE_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              last
);
  localparam int HI_W = ADDR_W - BYTE_W;

  assign last = (idx_q == IDX_W'(WORD_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (lo_we) begin
      addr_q[BYTE_W-1:0] <= wdata;
      idx_q              <= '0;
    end else if (hi_we) begin
      addr_q[ADDR_W-1:BYTE_W] <= wdata[HI_W-1:0];
      idx_q                   <= '0;
    end else if (step) begin
      if (last) begin
        idx_q  <= '0;
        addr_q <= addr_q + 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && !lo_we && !hi_we) |=> $stable(addr_q));       // R3
  AST_ADDR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !lo_we && !hi_we) |=> addr_q == $past(addr_q) + ADDR_W'(1)); // R7
  AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we || hi_we) |=> idx_q == '0);                              // R6
endmodule

// File: rtl/prl_word_ram.sv
module prl_word_ram
  import prl_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              last,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              commit,
  output logic [WORD_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] stage [WORD_BYTES-1];
  logic [WORD_W-1:0] commit_word;
  logic [WORD_W-1:0] mem [DEPTH];

  assign commit = byte_we && last;

  for (genvar g = 0; g < WORD_BYTES - 1; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   stage[g] <= '0;
      else if (byte_we && idx == IDX_W'(g))         stage[g] <= wdata;
    end
    assign commit_word[g*BYTE_W +: BYTE_W] = stage[g];
  end
  assign commit_word[WORD_W-1 -: BYTE_W] = wdata;

  always_ff @(posedge clk) begin
    if (commit) mem[addr] <= commit_word;
  end

  assign rword = mem[addr];

  AST_COMMIT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> idx == IDX_W'(WORD_BYTES - 1));                      // R2
endmodule

// File: rtl/prog_ram_loader.sv
module prog_ram_loader
  import prl_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic [7:0]        ctrl_o,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic              load_en;
  logic              ctrl_we, lo_we, hi_we;
  logic              data_acc, data_wr;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  idx;
  logic              idx_last;
  logic              ram_commit;
  logic [WORD_W-1:0] rword;

  assign load_en  = ctrl_o[CB_LOAD];
  assign ctrl_we  = host_wr && host_sel == SEL_CTRL;
  assign lo_we    = host_wr && host_sel == SEL_ADRLO;
  assign hi_we    = host_wr && host_sel == SEL_ADRHI;
  assign data_acc = (host_wr || host_rd) && host_sel == SEL_DATA && load_en;
  assign data_wr  = host_wr && host_sel == SEL_DATA && load_en;

  prl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(host_wdata),
    .ctrl_q(ctrl_o), .pc_q(pc_o)
  );

  prl_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .hi_we(hi_we),
    .step(data_acc), .wdata(host_wdata),
    .addr_q(addr), .idx_q(idx), .last(idx_last)
  );

  prl_word_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .byte_we(data_wr), .idx(idx), .last(idx_last),
    .addr(addr), .wdata(host_wdata), .commit(ram_commit), .rword(rword)
  );

  always_comb begin
    unique case (host_sel)
      SEL_CTRL:  host_rdata = ctrl_o;
      SEL_DATA:  host_rdata = load_en ? lane_of(rword, idx) : '0;
      SEL_ADRLO: host_rdata = addr[BYTE_W-1:0];
      default:   host_rdata = BYTE_W'(addr[ADDR_W-1:BYTE_W]);
    endcase
  end

  AST_NO_COMMIT_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_commit |-> load_en);                                        // R5
  AST_DATA_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel == SEL_DATA && !load_en) |-> host_rdata == '0);       // R5
  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel == SEL_ADRHI |-> (host_rdata >> HI_W) == '0);          // R4
endmodule

// File: tb/prog_ram_loader_bench.sv
module prog_ram_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    host_sel = 2'd0;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [7:0]    host_wdata = 8'h00;
  logic [7:0]    host_rdata;
  logic [7:0]    ctrl_o;
  logic [AW-1:0] pc_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_ram_loader #(.ADDR_W(AW)) u_prog_ram_loader (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ctrl_o(ctrl_o), .pc_o(pc_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  // read without a strobe: no side effect on the byte index
  task automatic peek(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel;
    #1 d = host_rdata;
  endtask

  task automatic wr_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) wr(2'd1, w[i*8 +: 8]);
  endtask

  task automatic set_addr(input logic [8:0] a);
    wr(2'd3, {7'd0, a[8]});
    wr(2'd2, a[7:0]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(2'd0, d); check("R1 ctrl", d, 8'h00);
    peek(2'd2, d); check("R1 addr lo", d, 8'h00);
    peek(2'd3, d); check("R1 addr hi", d, 8'h00);
    check("R1 pc", pc_o, 0);
    peek(2'd1, d); check("R5 data read unloaded", d, 8'h00);
  endtask

  task automatic t_ctrl_bits();
    logic [7:0] d;
    wr(2'd0, 8'hF9);
    peek(2'd0, d); check("R10 ctrl readback", d, 8'hF9);
    check("R10 ctrl_o", ctrl_o, 8'hF9);
    wr(2'd0, 8'h01);
    check("R10 ctrl_o load only", ctrl_o, 8'h01);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    set_addr(9'h010);
    wr(2'd1, 8'hEF); wr(2'd1, 8'hBE); wr(2'd1, 8'hAD);
    peek(2'd2, d); check("R3 addr hold after 3 bytes", d, 8'h10);
    wr(2'd1, 8'hDE);
    peek(2'd2, d); check("R3 addr advance after 4th byte", d, 8'h11);
    wr_word(32'h12345678);
    set_addr(9'h010);
    rd(2'd1, d); check("R2 R7 byte0", d, 8'hEF);
    rd(2'd1, d); check("R7 byte1", d, 8'hBE);
    rd(2'd1, d); check("R7 byte2", d, 8'hAD);
    peek(2'd2, d); check("R7 addr hold during reads", d, 8'h10);
    rd(2'd1, d); check("R2 R7 byte3", d, 8'hDE);
    peek(2'd2, d); check("R7 addr advance after 4th read", d, 8'h11);
    rd(2'd1, d); check("R2 second word byte0", d, 8'h78);
    rd(2'd1, d); rd(2'd1, d); rd(2'd1, d);
    check("R2 second word byte3", d, 8'h12);
  endtask

  task automatic t_high_and_wrap();
    logic [7:0] d;
    wr(2'd3, 8'hFF);
    peek(2'd3, d); check("R4 high reg keeps bit0", d, 8'h01);
    wr(2'd2, 8'hFF);
    wr_word(32'h0BADF00D);
    peek(2'd2, d); check("R3 wrap lo", d, 8'h00);
    peek(2'd3, d); check("R3 wrap hi", d, 8'h00);
    set_addr(9'h1FF);
    rd(2'd1, d); check("R4 word 511 byte0", d, 8'h0D);
    rd(2'd1, d); rd(2'd1, d); rd(2'd1, d);
    check("R4 word 511 byte3", d, 8'h0B);
  endtask

  task automatic t_index_reset();
    logic [7:0] d;
    set_addr(9'h020);
    wr(2'd1, 8'h11); wr(2'd1, 8'h22);
    wr(2'd2, 8'h20);
    wr_word(32'hDDCCBBAA);
    peek(2'd2, d); check("R6 one word after restart", d, 8'h21);
    set_addr(9'h020);
    rd(2'd1, d); rd(2'd1, d);
    check("R6 mid-word read", d, 8'hBB);
    wr(2'd2, 8'h20);
    rd(2'd1, d); check("R6 index back to byte0", d, 8'hAA);
  endtask

  task automatic t_gated();
    logic [7:0] d;
    set_addr(9'h010);
    wr(2'd0, 8'h00);
    for (int i = 0; i < 5; i++) wr(2'd1, 8'h55);
    peek(2'd2, d); check("R5 addr unchanged unloaded", d, 8'h10);
    rd(2'd1, d); check("R5 read zero unloaded", d, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd1, d); check("R5 memory and index untouched", d, 8'hEF);
  endtask

  task automatic t_pc();
    logic [7:0] d;
    wr(2'd0, 8'h04); wr(2'd0, 8'h04); wr(2'd0, 8'h04);
    check("R9 pc after 3 steps", pc_o, 3);
    wr(2'd0, 8'h05);
    check("R9 no step with load set", pc_o, 3);
    wr(2'd0, 8'h02);
    @(posedge clk); #1;
    check("R8 pc cleared", pc_o, 0);
    peek(2'd0, d); check("R8 reset bit self-clears", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ctrl_bits();
    t_write_read();
    t_high_and_wrap();
    t_index_reset();
    t_gated();
    t_pc();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule